// File: doc/BRIEF.md
# Coprocessor Run Control and Lock Register Block

This block sits between a host processor and a small embedded coprocessor. The host reaches it over a simple 32-bit register bus with separate read and write strobes and a word index. Through it the host starts and stops the core, clears the break condition the core raises, drives an interrupt request back to itself, places the core's program counter, and watches the DMA engine's busy and full flags.

Control writes are commands, not data. Each bit of a status write either sets or clears one flag, so the host never needs a read-modify-write to change a single flag. When the core hits a break instruction it pulses `core_brk`, and that stops the core until the host clears the flags. A hardware lock that is taken on read and released on write lets the host and the core decide which of them owns a shared resource. When both try in the same cycle, exactly one of them wins.

The register index map is: status at word 0, program counter at word 1, lock at word 2. `bus_rdata` is registered. It carries the value of a read on the clock cycle after the read strobe and holds it until the next read.

Top module: `ccsr_top`

## Requirements
- R1: After reset, halt is 1, break is 0, the interrupt flag is 0 (`host_irq` low), the lock is free (reads 0), and `pc_out` is 0.
- R2: On a status write, each data bit is a command: bit 0 clears halt, bit 1 sets halt, bit 2 clears break, bit 3 clears the interrupt flag, and bit 4 sets it. A write of 0x5 clears both halt and break.
- R3: If one status write carries both the set and the clear bit of the same flag, that flag keeps its value. Data bits 31:5 of a status write have no effect.
- R4: A `core_brk` pulse sets both halt and break by the next cycle. It wins over a host clear of those flags in the same cycle.
- R5: `host_irq` is the interrupt flag ANDed with the `irq_en` input.
- R6: A status read returns halt in bit 0, break in bit 1, `dma_busy` in bit 2, `dma_full` in bit 3 and the interrupt flag in bit 4. All other bits read 0.
- R7: A program-counter write loads data bits 11:0, and a read returns that value with zeros above it. A core update through `core_pc_en` takes effect only while halt is 0. A host write in the same cycle wins.
- R8: A host lock read returns the lock's current value and then leaves it at 1. A core acquire reports the prior value on `core_sem_seen` one cycle later and also leaves the lock at 1. A host lock write (any data) or a `core_sem_rel` pulse frees the lock, unless an acquire happens in the same cycle.
- R9: When a host lock read and a core acquire fall in the same cycle, the host is served first: it sees the prior value and the core sees 1.
- R10: Reads of word indices other than 0, 1 and 2 return 0. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 4 | Word index of the register |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Registered read data |
| dma_busy | input | 1 | DMA engine is moving data |
| dma_full | input | 1 | DMA request queue is full |
| irq_en | input | 1 | External mask enabling the host interrupt |
| host_irq | output | 1 | Interrupt request to the host |
| core_brk | input | 1 | Break instruction pulse from the core |
| core_pc_en | input | 1 | Core advances its program counter |
| core_pc_nxt | input | 12 | Next program counter from the core |
| core_sem_req | input | 1 | Core attempts to acquire the lock |
| core_sem_rel | input | 1 | Core releases the lock |
| core_sem_seen | output | 1 | Lock value the core's last acquire saw |
| halted | output | 1 | Core halt flag |
| brk_flag | output | 1 | Break flag |
| pc_out | output | 12 | Program counter |

## Verification
Random status writes use all 32 data values of the command field, with the upper data bits also random. This separates single set or clear commands from set-and-clear pairs, which must leave the flag unchanged. Break pulses are mixed in, some of them in the same cycle as a host clear, to show that the core's stop wins. Lock traffic interleaves host reads, host writes, core acquires, core releases and same-cycle races, which shows whether exactly one party wins and whether the host has priority. Core program-counter updates are applied both while halted and while running, so a counter that moves during halt is exposed.

// File: rtl/ccsr_pkg.sv
package ccsr_pkg;
   // command bit positions of a status write
   localparam int unsigned CMD_CLR_HALT = 0;
   localparam int unsigned CMD_SET_HALT = 1;
   localparam int unsigned CMD_CLR_BRK  = 2;
   localparam int unsigned CMD_CLR_IRQ  = 3;
   localparam int unsigned CMD_SET_IRQ  = 4;
   localparam int unsigned CMD_W        = 5;

   // field positions of a status read
   localparam int unsigned ST_HALT     = 0;
   localparam int unsigned ST_BRK      = 1;
   localparam int unsigned ST_DMA_BUSY = 2;
   localparam int unsigned ST_DMA_FULL = 3;
   localparam int unsigned ST_IRQ      = 4;

   // flag slots held in the set/clear flag bank
   localparam int unsigned FLG_HALT = 0;
   localparam int unsigned FLG_BRK  = 1;
   localparam int unsigned FLG_IRQ  = 2;
   localparam int unsigned NFLAG    = 3;

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_STATUS = 2'd1,
      SEL_PC     = 2'd2,
      SEL_SEM    = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/ccsr_sc_flag.sv
module ccsr_sc_flag #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= RST_VAL;
      else if (set_i && !clr_i)
         q <= 1'b1;
      else if (clr_i && !set_i)
         q <= 1'b0;
   end

   assign q_o = q;
endmodule

// File: rtl/ccsr_flag_bank.sv
module ccsr_flag_bank
   import ccsr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stat_we,
   input  logic [CMD_W-1:0]  cmd,
   input  logic              core_brk,
   output logic [NFLAG-1:0]  flags
);
   localparam logic [NFLAG-1:0] RST_VEC = NFLAG'(1) << FLG_HALT;

   logic [NFLAG-1:0] set_v;
   logic [NFLAG-1:0] clr_v;
   logic [CMD_W-1:0] cmd_g;

   assign cmd_g = stat_we ? cmd : '0;

   always_comb begin
      set_v = '0;
      clr_v = '0;
      // a break stop dominates any host clear in the same cycle
      set_v[FLG_HALT] = cmd_g[CMD_SET_HALT] | core_brk;
      clr_v[FLG_HALT] = cmd_g[CMD_CLR_HALT] & ~core_brk;
      set_v[FLG_BRK]  = core_brk;
      clr_v[FLG_BRK]  = cmd_g[CMD_CLR_BRK] & ~core_brk;
      set_v[FLG_IRQ]  = cmd_g[CMD_SET_IRQ];
      clr_v[FLG_IRQ]  = cmd_g[CMD_CLR_IRQ];
   end

   for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
      ccsr_sc_flag #(
         .RST_VAL (RST_VEC[gi])
      ) u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (set_v[gi]),
         .clr_i (clr_v[gi]),
         .q_o   (flags[gi])
      );
   end
endmodule

// File: rtl/ccsr_lock.sv
module ccsr_lock (
   input  logic clk,
   input  logic rst_n,
   input  logic host_acq,
   input  logic host_rel,
   input  logic core_acq,
   input  logic core_rel,
   output logic lock_q,
   output logic core_seen
);
   logic lock;
   logic seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock <= 1'b0;
         seen <= 1'b0;
      end else begin
         if (host_acq || core_acq)
            lock <= 1'b1;
         else if (host_rel || core_rel)
            lock <= 1'b0;
         // host is served first: a simultaneous core attempt sees it taken
         if (core_acq)
            seen <= host_acq ? 1'b1 : lock;
      end
   end

   assign lock_q    = lock;
   assign core_seen = seen;
endmodule

// File: rtl/ccsr_pc.sv
module ccsr_pc #(
   parameter int unsigned PC_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            host_we,
   input  logic [PC_W-1:0] host_d,
   input  logic            core_en,
   input  logic [PC_W-1:0] core_d,
   input  logic            halted,
   output logic [PC_W-1:0] pc_q
);
   logic [PC_W-1:0] pc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pc <= '0;
      else if (host_we)
         pc <= host_d;
      else if (core_en && !halted)
         pc <= core_d;
   end

   assign pc_q = pc;
endmodule

// File: rtl/ccsr_top.sv
module ccsr_top
   import ccsr_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned PC_W       = 12,
   parameter int unsigned STATUS_IDX = 0,
   parameter int unsigned PC_IDX     = 1,
   parameter int unsigned SEM_IDX    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              dma_busy,
   input  logic              dma_full,
   input  logic              irq_en,
   output logic              host_irq,
   input  logic              core_brk,
   input  logic              core_pc_en,
   input  logic [PC_W-1:0]   core_pc_nxt,
   input  logic              core_sem_req,
   input  logic              core_sem_rel,
   output logic              core_sem_seen,
   output logic              halted,
   output logic              brk_flag,
   output logic [PC_W-1:0]   pc_out
);
   localparam int unsigned NREG = 1 << ADDR_W;

   // elaboration-time parameter checks
   if (DATA_W < CMD_W) begin : g_bad_data_w
      $error("DATA_W must hold the status command field");
   end
   if (PC_W > DATA_W || PC_W == 0) begin : g_bad_pc_w
      $error("PC_W must be between 1 and DATA_W");
   end
   if (STATUS_IDX >= NREG || PC_IDX >= NREG || SEM_IDX >= NREG) begin : g_bad_idx
      $error("register index does not fit in ADDR_W");
   end
   if (STATUS_IDX == PC_IDX || STATUS_IDX == SEM_IDX || PC_IDX == SEM_IDX) begin : g_dup_idx
      $error("register indices must be distinct");
   end

   reg_sel_e         sel;
   logic [NFLAG-1:0] flags;
   logic             lock_q;
   logic [PC_W-1:0]  pc_q;
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rdata_q;

   always_comb begin
      if (bus_addr == ADDR_W'(STATUS_IDX))
         sel = SEL_STATUS;
      else if (bus_addr == ADDR_W'(PC_IDX))
         sel = SEL_PC;
      else if (bus_addr == ADDR_W'(SEM_IDX))
         sel = SEL_SEM;
      else
         sel = SEL_NONE;
   end

   ccsr_flag_bank u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .stat_we  (bus_wr && sel == SEL_STATUS),
      .cmd      (bus_wdata[CMD_W-1:0]),
      .core_brk (core_brk),
      .flags    (flags)
   );

   ccsr_lock u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_acq  (bus_rd && sel == SEL_SEM),
      .host_rel  (bus_wr && sel == SEL_SEM),
      .core_acq  (core_sem_req),
      .core_rel  (core_sem_rel),
      .lock_q    (lock_q),
      .core_seen (core_sem_seen)
   );

   ccsr_pc #(
      .PC_W (PC_W)
   ) u_pc (
      .clk     (clk),
      .rst_n   (rst_n),
      .host_we (bus_wr && sel == SEL_PC),
      .host_d  (bus_wdata[PC_W-1:0]),
      .core_en (core_pc_en),
      .core_d  (core_pc_nxt),
      .halted  (flags[FLG_HALT]),
      .pc_q    (pc_q)
   );

   always_comb begin
      rd_mux = '0;
      unique case (sel)
         SEL_STATUS: begin
            rd_mux[ST_HALT]     = flags[FLG_HALT];
            rd_mux[ST_BRK]      = flags[FLG_BRK];
            rd_mux[ST_DMA_BUSY] = dma_busy;
            rd_mux[ST_DMA_FULL] = dma_full;
            rd_mux[ST_IRQ]      = flags[FLG_IRQ];
         end
         SEL_PC:  rd_mux[PC_W-1:0] = pc_q;
         SEL_SEM: rd_mux[0] = lock_q;
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (bus_rd)
         rdata_q <= rd_mux;
   end

   if (PC_W < DATA_W) begin : g_wd_spare
      logic unused_wd;
      assign unused_wd = ^bus_wdata[DATA_W-1:PC_W];
   end

   assign bus_rdata = rdata_q;
   assign host_irq  = flags[FLG_IRQ] & irq_en;
   assign halted    = flags[FLG_HALT];
   assign brk_flag  = flags[FLG_BRK];
   assign pc_out    = pc_q;
endmodule

// File: rtl/ccsr_chk.sv
module ccsr_chk #(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned PC_W       = 12,
   parameter int unsigned STATUS_IDX = 0,
   parameter int unsigned PC_IDX     = 1,
   parameter int unsigned SEM_IDX    = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [1:0]        halt_cmd,
   input logic              bus_rdata0,
   input logic              core_brk,
   input logic              core_sem_req,
   input logic              core_sem_seen,
   input logic              halted,
   input logic              brk_flag,
   input logic [PC_W-1:0]   pc_out
);
   // R4
   brk_stops_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_brk |=> (halted && brk_flag));

   // R3
   halt_pair_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(STATUS_IDX) && halt_cmd == 2'b11 && !core_brk)
      |=> $stable(halted));

   // R7
   pc_frozen_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !(bus_wr && bus_addr == ADDR_W'(PC_IDX))) |=> $stable(pc_out));

   // R9
   core_loses_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(SEM_IDX) && core_sem_req) |=> core_sem_seen);

   // R9
   one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(SEM_IDX) && core_sem_req)
      |=> (bus_rdata0 || core_sem_seen));
endmodule

bind ccsr_top ccsr_chk #(
   .ADDR_W     (ADDR_W),
   .PC_W       (PC_W),
   .STATUS_IDX (STATUS_IDX),
   .PC_IDX     (PC_IDX),
   .SEM_IDX    (SEM_IDX)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bus_wr        (bus_wr),
   .bus_rd        (bus_rd),
   .bus_addr      (bus_addr),
   .halt_cmd      (bus_wdata[1:0]),
   .bus_rdata0    (bus_rdata[0]),
   .core_brk      (core_brk),
   .core_sem_req  (core_sem_req),
   .core_sem_seen (core_sem_seen),
   .halted        (halted),
   .brk_flag      (brk_flag),
   .pc_out        (pc_out)
);

// File: tb/ccsr_top_tb.sv
`timescale 1ns/1ps
module ccsr_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 0, bus_rd = 0;
   logic [3:0]  bus_addr = 0;
   logic [31:0] bus_wdata = 0;
   logic [31:0] bus_rdata;
   logic        dma_busy = 0, dma_full = 0, irq_en = 0;
   logic        host_irq;
   logic        core_brk = 0, core_pc_en = 0;
   logic [11:0] core_pc_nxt = 0;
   logic        core_sem_req = 0, core_sem_rel = 0;
   logic        core_sem_seen, halted, brk_flag;
   logic [11:0] pc_out;

   int n_cmp = 0;
   int n_bad = 0;

   // bench model
   bit       m_halt, m_brk, m_irq, m_sem;
   bit [11:0] m_pc;

   always #2.5 clk = ~clk;

   ccsr_top u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .dma_busy(dma_busy), .dma_full(dma_full), .irq_en(irq_en),
      .host_irq(host_irq), .core_brk(core_brk), .core_pc_en(core_pc_en),
      .core_pc_nxt(core_pc_nxt), .core_sem_req(core_sem_req),
      .core_sem_rel(core_sem_rel), .core_sem_seen(core_sem_seen),
      .halted(halted), .brk_flag(brk_flag), .pc_out(pc_out)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_status(bit busy, bit full);
      return {27'b0, m_irq, full, busy, m_brk, m_halt};
   endfunction

   // R2 R3 command semantics
   function automatic void model_status_wr(logic [31:0] d);
      if (d[1] && !d[0]) m_halt = 1; else if (d[0] && !d[1]) m_halt = 0;
      if (d[2]) m_brk = 0;
      if (d[4] && !d[3]) m_irq = 1; else if (d[3] && !d[4]) m_irq = 0;
   endfunction

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 0;
      if (a == 0) model_status_wr(d);
      else if (a == 1) m_pc = d[11:0];
      else if (a == 2) m_sem = 0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1; bus_addr = a;
      @(negedge clk);
      bus_rd = 0;
      d = bus_rdata;
   endtask

   task automatic check_flags(input string tag);
      check({tag, " halted"}, {31'b0, halted}, {31'b0, m_halt});
      check({tag, " brk"}, {31'b0, brk_flag}, {31'b0, m_brk});
      check({tag, " R5 irq"}, {31'b0, host_irq}, {31'b0, m_irq & irq_en});
   endtask

   task automatic read_status(input string tag);
      logic [31:0] d;
      bit b, f;
      b = 1'($urandom); f = 1'($urandom);
      dma_busy = b; dma_full = f;
      bus_read(0, d);
      check({tag, " R6 status"}, d, exp_status(b, f));
   endtask

   task automatic host_lock_read(input string tag);
      logic [31:0] d;
      logic [31:0] e;
      e = {31'b0, m_sem};
      bus_read(2, d);
      m_sem = 1;
      check({tag, " R8 host lock"}, d, e);
   endtask

   task automatic core_acquire(input string tag);
      bit e;
      e = m_sem;
      @(negedge clk); core_sem_req = 1;
      @(negedge clk); core_sem_req = 0;
      m_sem = 1;
      check({tag, " R8 core lock"}, {31'b0, core_sem_seen}, {31'b0, e});
   endtask

   task automatic core_release();
      @(negedge clk); core_sem_rel = 1;
      @(negedge clk); core_sem_rel = 0;
      m_sem = 0;
   endtask

   task automatic lock_race(input string tag);
      bit e;
      e = m_sem;
      @(negedge clk);
      bus_rd = 1; bus_addr = 2; core_sem_req = 1;
      @(negedge clk);
      bus_rd = 0; core_sem_req = 0;
      m_sem = 1;
      check({tag, " R9 host"}, bus_rdata, {31'b0, e});
      check({tag, " R9 core"}, {31'b0, core_sem_seen}, 32'd1);
   endtask

   task automatic brk_pulse(input bit with_clear);
      @(negedge clk);
      core_brk = 1;
      if (with_clear) begin bus_wr = 1; bus_addr = 0; bus_wdata = 32'h5; end
      @(negedge clk);
      core_brk = 0; bus_wr = 0;
      if (with_clear) model_status_wr(32'h5);
      m_halt = 1; m_brk = 1;
      check_flags("R4 brk");
   endtask

   task automatic core_step(input logic [11:0] v);
      @(negedge clk); core_pc_en = 1; core_pc_nxt = v;
      @(negedge clk); core_pc_en = 0;
      if (!m_halt) m_pc = v;
      check("R7 core pc", {20'b0, pc_out}, {20'b0, m_pc});
   endtask

   initial begin
      logic [31:0] d;
      void'($urandom(32'd7741));
      repeat (3) @(negedge clk);
      rst_n = 1;
      m_halt = 1; m_brk = 0; m_irq = 0; m_sem = 0; m_pc = 0;
      // R1 reset state
      irq_en = 1;
      @(negedge clk);
      check_flags("R1 reset");
      check("R1 pc", {20'b0, pc_out}, 32'd0);
      dma_busy = 0; dma_full = 0;
      bus_read(0, d);
      check("R1 status", d, 32'h1);
      host_lock_read("R1");
      bus_write(2, 32'h0);

      // directed R2: start core, break, irq set/clear
      bus_write(0, 32'h5); check_flags("R2 run");
      brk_pulse(0);
      read_status("R2");
      bus_write(0, 32'h10); check_flags("R2 irq set");
      irq_en = 0; @(negedge clk); check_flags("R5 masked");
      irq_en = 1;
      bus_write(0, 32'h8); check_flags("R2 irq clr");
      // R3 pairs and upper bits
      bus_write(0, 32'hFFFF_FFE3); check_flags("R3 pair halt");
      bus_write(0, 32'h18); check_flags("R3 pair irq");
      bus_write(0, 32'h1); check_flags("R2 clr halt");
      // R4 break beats a same-cycle clear
      brk_pulse(1);
      // R7 pc while halted and running
      bus_write(1, 32'hABCD_E123);
      bus_read(1, d); check("R7 pc rd", d, 32'h123);
      core_step(12'h456);
      bus_write(0, 32'h5);
      core_step(12'h789);
      bus_read(1, d); check("R7 pc run rd", d, {20'b0, m_pc});
      bus_write(0, 32'h2);
      // R8 / R9 lock
      host_lock_read("R8 a"); host_lock_read("R8 b");
      core_acquire("R8 c"); bus_write(2, 32'hDEAD);
      core_acquire("R8 d"); host_lock_read("R8 e"); core_release();
      lock_race("R9 free"); lock_race("R9 held");
      bus_write(2, 0);
      // R10 undefined words
      bus_write(4'h7, 32'hFFFF_FFFF);
      bus_read(4'hF, d); check("R10 undef rd", d, 32'h0);
      read_status("R10");
      check("R10 pc", {20'b0, pc_out}, {20'b0, m_pc});

      // random mix
      for (int i = 0; i < 600; i++) begin
         int op;
         op = int'($urandom_range(0, 11));
         irq_en = 1'($urandom);
         case (op)
            0, 1: bus_write(0, $urandom);
            2:    read_status("rnd");
            3:    bus_write(1, $urandom);
            4:    begin bus_read(1, d); check("R7 rnd pc", d, {20'b0, m_pc}); end
            5:    host_lock_read("rnd");
            6:    bus_write(2, $urandom);
            7:    core_acquire("rnd");
            8:    if ($urandom_range(0, 3) == 0) brk_pulse(1'($urandom)); else core_release();
            9:    core_step(12'($urandom));
            10:   lock_race("rnd");
            default: begin
               bus_write(4'($urandom_range(3, 15)), $urandom);
               bus_read(4'($urandom_range(3, 15)), d);
               check("R10 rnd undef", d, 32'h0);
            end
         endcase
         check_flags("rnd");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule